// File: doc/BRIEF.md
# SD SPI Command Engine

This block sends a single SD-card command in SPI mode and gathers the card's reply. The host side presents a 6-bit command index, a 32-bit argument, a reply-type selector and an "application command" flag, then pulses a start input. The engine selects the card and frames the 6-byte command with a fixed checksum byte. It then polls for the R1 status byte, reads a 4-byte trailer or waits out a busy period as the reply type asks, and deselects the card. Finally it pulses done, with the results held on its outputs.

Bytes move through an external byte-wide SPI master over a start/done handshake: the engine raises `spi_start` for one cycle with the byte to send, and the master returns the received byte on `spi_rx` with a one-cycle `spi_done`. Only one byte is ever in flight. Chip select is driven directly by the engine. Data blocks, card bring-up policy and bit shifting belong to other blocks.

Top module: `sd_cmd_engine`

## Requirements
- R1: Frame byte 0 is `0x40 | index` (bits 7:6 = 01, bits 5:0 = index); frame bytes 1 to 4 are the argument, bits 31:24 first and bits 7:0 last.
- R2: Frame byte 5 is 0x95 when the index is 0, 0x87 when the index is 8, and 0xFF for every other index.
- R3: A command opens with one 0xFF byte sent while `cs_n` is 1, after which `cs_n` is 0 for the frame; it closes by setting `cs_n` to 1 and then sending one 0xFF byte. `cs_n` is 1 whenever the engine is idle.
- R4: After the frame the engine sends up to 16 filler bytes (0xFF). The first received byte with bit 7 clear becomes `r1_status`, and polling stops there.
- R5: When the index is 12, one extra filler byte follows the frame, and whatever it returns is discarded before polling starts.
- R6: If 16 polls bring no valid byte, the whole command (including the preceding CMD55 when `req_app` is 1) is repeated. After 3 attempts without a reply, `no_response` is 1 and `r1_status` is 0xFF.
- R7: With `req_kind` = 2, four further bytes are read after R1 and packed first-received-most-significant into `trailer`; for any other kind `trailer` is 0.
- R8: With `req_kind` = 1, filler bytes are sent after R1 until a received byte equals 0xFF.
- R9: If the busy wait of R8 lasts `BUSY_LIMIT` clock cycles without 0xFF, the engine stops waiting, deselects, and reports `busy_timeout` = 1 with done.
- R10: With `req_app` = 1, a CMD55 frame with argument 0 is sent and polled first. Then filler bytes are sent until 0xFF is received (or `READY_LIMIT` cycles pass), and then the requested command is framed.
- R11: If R1 has bit 2 (illegal command) or bit 3 (command checksum error) set, no trailer is read and no busy wait is done; the engine goes straight to deselect.
- R12: `done` is a single-cycle pulse. `r1_status`, `trailer`, `no_response` and `busy_timeout` hold until the next start, and `spi_start` is never raised twice without an intervening `spi_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start a command (taken when idle) |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_kind | input | 2 | Reply type: 0 plain R1, 1 R1 plus busy, 2 R1 plus 32-bit trailer |
| req_app | input | 1 | Precede the command with CMD55 |
| busy | output | 1 | Engine is working on a command |
| done | output | 1 | One-cycle completion pulse |
| r1_status | output | 8 | R1 status byte, 0xFF if none |
| trailer | output | 32 | Trailer word for reply type 2 |
| no_response | output | 1 | No valid R1 after all attempts |
| busy_timeout | output | 1 | Busy wait ended by timeout |
| cs_n | output | 1 | Card chip select, active low |
| spi_start | output | 1 | Byte transfer request to the SPI master |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | Byte transfer finished |
| spi_rx | input | 8 | Byte received |

## Verification
The bench places a card model behind the byte handshake. The model logs every byte sent with the chip-select level it was sent under, and replies from a per-test script. It targets the stop command's stuff byte: the script returns a byte with bit 7 clear there, so an engine that polls too soon reports the wrong status. It also puts the reply on the sixteenth and last poll, where an off-by-one window turns the command into a retry. The bench counts the bytes of a triple no-response run, so a missing or extra retry changes the total. An R1 with the illegal-command bit is followed by trailer-like bytes that a careless engine would swallow, and a busy line that never releases must end in the timeout flag rather than a hang.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [1:0] {
        RESP_R1        = 2'd0,
        RESP_R1_BUSY   = 2'd1,
        RESP_R1_WORD   = 2'd2
    } resp_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SELECT,
        ST_FRAME,
        ST_STUFF,
        ST_POLL,
        ST_READY,
        ST_TRAIL,
        ST_BUSY,
        ST_DESELECT
    } seq_state_e;

    typedef struct packed {
        logic [5:0]  index;
        logic [31:0] arg;
    } cmd_word_t;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [5:0] IDX_RESET   = 6'd0;
    localparam logic [5:0] IDX_IFCOND  = 6'd8;
    localparam logic [5:0] IDX_STOP    = 6'd12;
    localparam logic [5:0] IDX_APPCMD  = 6'd55;

    // Fixed checksum byte: the two commands that need a valid one get it,
    // every other command gets all ones (end bit high).
    function automatic logic [7:0] tail_byte(input logic [5:0] idx);
        if (idx == IDX_RESET)       return 8'h95;
        else if (idx == IDX_IFCOND) return 8'h87;
        else                        return FILL_BYTE;
    endfunction

    // R1 flags that abort the rest of the reply
    function automatic logic r1_fatal(input logic [7:0] r1);
        return r1[2] | r1[3];
    endfunction

endpackage

// File: rtl/sdc_framer.sv
module sdc_framer
    import sdc_pkg::*;
(
    input  cmd_word_t  cmd,
    input  logic [2:0] pos,
    output logic [7:0] frame_byte
);
    always_comb begin
        case (pos)
            3'd0:    frame_byte = {2'b01, cmd.index};
            3'd1:    frame_byte = cmd.arg[31:24];
            3'd2:    frame_byte = cmd.arg[23:16];
            3'd3:    frame_byte = cmd.arg[15:8];
            3'd4:    frame_byte = cmd.arg[7:0];
            3'd5:    frame_byte = tail_byte(cmd.index);
            default: frame_byte = FILL_BYTE;
        endcase
    end
endmodule

// File: rtl/sdc_byte_port.sv
module sdc_byte_port
    import sdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       issue,
    input  logic [7:0] tx_in,
    input  logic       spi_done,
    output logic       spi_start,
    output logic [7:0] spi_tx,
    output logic       pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            spi_start <= 1'b0;
            spi_tx    <= FILL_BYTE;
            pending   <= 1'b0;
        end else begin
            spi_start <= 1'b0;
            if (issue && !pending) begin
                spi_start <= 1'b1;
                spi_tx    <= tx_in;
                pending   <= 1'b1;
            end else if (spi_done) begin
                pending   <= 1'b0;
            end
        end
    end

    // R12
    single_start_chk: assert property (@(posedge clk) disable iff (rst)
        spi_start |=> !spi_start);

    // R12
    in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && !spi_done) |=> !spi_start);
endmodule

// File: rtl/sdc_cycle_timer.sv
module sdc_cycle_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (run && cnt != W'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == W'(LIMIT));

    // R9
    timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (expired && !clear) |=> expired);
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sdc_pkg::*;
#(
    parameter int unsigned POLL_LIMIT  = 16,
    parameter int unsigned ATTEMPTS    = 3,
    parameter int unsigned BUSY_LIMIT  = 100000,
    parameter int unsigned READY_LIMIT = 100000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_start,
    input  logic [5:0]  req_index,
    input  logic [31:0] req_arg,
    input  logic [1:0]  req_kind,
    input  logic        req_app,
    output logic        busy,
    output logic        done,
    output logic [7:0]  r1_status,
    output logic [31:0] trailer,
    output logic        no_response,
    output logic        busy_timeout,
    output logic        cs_n,
    output logic        spi_start,
    output logic [7:0]  spi_tx,
    input  logic        spi_done,
    input  logic [7:0]  spi_rx
);
    localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam int ATT_W  = $clog2(ATTEMPTS + 1);

    seq_state_e          state;
    cmd_word_t           cmd_q;
    resp_kind_e          kind_q;
    logic                app_q;
    logic                app_phase;
    logic [2:0]          frame_pos;
    logic [POLL_W-1:0]   poll_cnt;
    logic [1:0]          trail_cnt;
    logic [ATT_W-1:0]    attempt;
    logic                cs_q;
    logic                done_q;
    logic [7:0]          r1_q;
    logic [31:0]         trailer_q;
    logic                noresp_q;
    logic                tmo_q;

    cmd_word_t           cur_cmd;
    logic [7:0]          frame_byte;
    logic [7:0]          tx_byte;
    logic                want_byte;
    logic                pending;
    logic                byte_done;
    logic                busy_expired;
    logic                ready_expired;

    assign cur_cmd = app_phase ? '{index: IDX_APPCMD, arg: 32'h0} : cmd_q;

    sdc_framer u_framer (
        .cmd        (cur_cmd),
        .pos        (frame_pos),
        .frame_byte (frame_byte)
    );

    assign want_byte = (state != ST_IDLE);
    assign tx_byte   = (state == ST_FRAME) ? frame_byte : FILL_BYTE;

    sdc_byte_port u_port (
        .clk       (clk),
        .rst       (rst),
        .issue     (want_byte),
        .tx_in     (tx_byte),
        .spi_done  (spi_done),
        .spi_start (spi_start),
        .spi_tx    (spi_tx),
        .pending   (pending)
    );

    assign byte_done = spi_done && pending;

    sdc_cycle_timer #(.LIMIT(BUSY_LIMIT)) u_busy_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (state != ST_BUSY),
        .run     (state == ST_BUSY),
        .expired (busy_expired)
    );

    sdc_cycle_timer #(.LIMIT(READY_LIMIT)) u_ready_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (state != ST_READY),
        .run     (state == ST_READY),
        .expired (ready_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cmd_q     <= '0;
            kind_q    <= RESP_R1;
            app_q     <= 1'b0;
            app_phase <= 1'b0;
            frame_pos <= '0;
            poll_cnt  <= '0;
            trail_cnt <= '0;
            attempt   <= '0;
            cs_q      <= 1'b1;
            done_q    <= 1'b0;
            r1_q      <= FILL_BYTE;
            trailer_q <= '0;
            noresp_q  <= 1'b0;
            tmo_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_start) begin
                        cmd_q     <= '{index: req_index, arg: req_arg};
                        kind_q    <= resp_kind_e'(req_kind);
                        app_q     <= req_app;
                        attempt   <= '0;
                        r1_q      <= FILL_BYTE;
                        trailer_q <= '0;
                        noresp_q  <= 1'b0;
                        tmo_q     <= 1'b0;
                        state     <= ST_SELECT;
                    end
                end
                ST_SELECT: begin
                    if (byte_done) begin
                        cs_q      <= 1'b0;
                        app_phase <= app_q;
                        frame_pos <= '0;
                        state     <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (byte_done) begin
                        if (frame_pos == 3'd5) begin
                            poll_cnt <= '0;
                            if (!app_phase && cmd_q.index == IDX_STOP)
                                state <= ST_STUFF;
                            else
                                state <= ST_POLL;
                        end else begin
                            frame_pos <= frame_pos + 3'd1;
                        end
                    end
                end
                ST_STUFF: begin
                    if (byte_done)
                        state <= ST_POLL;
                end
                ST_POLL: begin
                    if (byte_done) begin
                        if (!spi_rx[7]) begin
                            if (app_phase) begin
                                state <= ST_READY;
                            end else begin
                                r1_q <= spi_rx;
                                if (r1_fatal(spi_rx)) begin
                                    cs_q  <= 1'b1;
                                    state <= ST_DESELECT;
                                end else if (kind_q == RESP_R1_BUSY) begin
                                    state <= ST_BUSY;
                                end else if (kind_q == RESP_R1_WORD) begin
                                    trail_cnt <= '0;
                                    state     <= ST_TRAIL;
                                end else begin
                                    cs_q  <= 1'b1;
                                    state <= ST_DESELECT;
                                end
                            end
                        end else if (poll_cnt == POLL_W'(POLL_LIMIT - 1)) begin
                            if (app_phase) begin
                                state <= ST_READY;
                            end else if (attempt == ATT_W'(ATTEMPTS - 1)) begin
                                r1_q     <= FILL_BYTE;
                                noresp_q <= 1'b1;
                                cs_q     <= 1'b1;
                                state    <= ST_DESELECT;
                            end else begin
                                attempt   <= attempt + 1'b1;
                                app_phase <= app_q;
                                frame_pos <= '0;
                                state     <= ST_FRAME;
                            end
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                        end
                    end
                end
                ST_READY: begin
                    if (byte_done && (spi_rx == FILL_BYTE || ready_expired)) begin
                        app_phase <= 1'b0;
                        frame_pos <= '0;
                        state     <= ST_FRAME;
                    end
                end
                ST_TRAIL: begin
                    if (byte_done) begin
                        trailer_q <= {trailer_q[23:0], spi_rx};
                        if (trail_cnt == 2'd3) begin
                            cs_q  <= 1'b1;
                            state <= ST_DESELECT;
                        end else begin
                            trail_cnt <= trail_cnt + 2'd1;
                        end
                    end
                end
                ST_BUSY: begin
                    if (byte_done) begin
                        if (spi_rx == FILL_BYTE) begin
                            cs_q  <= 1'b1;
                            state <= ST_DESELECT;
                        end else if (busy_expired) begin
                            tmo_q <= 1'b1;
                            cs_q  <= 1'b1;
                            state <= ST_DESELECT;
                        end
                    end
                end
                ST_DESELECT: begin
                    if (byte_done) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state != ST_IDLE);
    assign done         = done_q;
    assign r1_status    = r1_q;
    assign trailer      = trailer_q;
    assign no_response  = noresp_q;
    assign busy_timeout = tmo_q;
    assign cs_n         = cs_q;

    // R3
    idle_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> cs_n);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    r1_msb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !no_response) |-> !r1_status[7]);

    // R6
    noresp_value_chk: assert property (@(posedge clk) disable iff (rst)
        (done && no_response) |-> (r1_status == 8'hFF));

    // R9
    timeout_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (done && busy_timeout) |-> (kind_q == RESP_R1_BUSY));

    // R11
    fatal_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POLL && byte_done && !app_phase && !spi_rx[7] && (spi_rx[2] || spi_rx[3]))
        |=> (state == ST_DESELECT));
endmodule

// File: tb/sd_cmd_engine_test.sv
module sd_cmd_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_start = 1'b0;
    logic [5:0]  req_index = '0;
    logic [31:0] req_arg = '0;
    logic [1:0]  req_kind = '0;
    logic        req_app = 1'b0;
    logic        busy, done, no_response, busy_timeout, cs_n, spi_start;
    logic [7:0]  r1_status, spi_tx;
    logic [31:0] trailer;
    logic        spi_done = 1'b0;
    logic [7:0]  spi_rx = 8'hFF;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    sd_cmd_engine #(
        .POLL_LIMIT(16), .ATTEMPTS(3), .BUSY_LIMIT(40), .READY_LIMIT(40)
    ) uut (
        .clk(clk), .rst(rst), .req_start(req_start), .req_index(req_index),
        .req_arg(req_arg), .req_kind(req_kind), .req_app(req_app),
        .busy(busy), .done(done), .r1_status(r1_status), .trailer(trailer),
        .no_response(no_response), .busy_timeout(busy_timeout), .cs_n(cs_n),
        .spi_start(spi_start), .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx)
    );

    // Card model: scripted replies, logs every byte with its chip select.
    logic [7:0] rx_script [0:127];
    logic [7:0] rx_default = 8'hFF;
    logic [7:0] tx_log [0:127];
    logic       cs_log [0:127];
    int         nbytes = 0;
    logic       log_clear = 1'b0;
    logic [7:0] rx_next = 8'hFF;
    int         dly = 0;

    always @(posedge clk) begin
        spi_done <= 1'b0;
        if (log_clear) begin
            nbytes <= 0;
            dly    <= 0;
        end else if (spi_start) begin
            if (nbytes < 128) begin
                tx_log[nbytes] <= spi_tx;
                cs_log[nbytes] <= cs_n;
                rx_next        <= rx_script[nbytes];
            end else begin
                rx_next        <= rx_default;
            end
            nbytes <= nbytes + 1;
            dly    <= 2;
        end else if (dly == 1) begin
            spi_done <= 1'b1;
            spi_rx   <= rx_next;
            dly      <= 0;
        end else if (dly != 0) begin
            dly <= dly - 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic prep(input logic [7:0] fill);
        for (int i = 0; i < 128; i++) rx_script[i] = fill;
        rx_default = fill;
        @(negedge clk);
        log_clear = 1'b1;
        @(negedge clk);
        log_clear = 1'b0;
    endtask

    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input logic [1:0] kind, input logic app);
        int waited = 0;
        @(negedge clk);
        req_index = idx; req_arg = arg; req_kind = kind; req_app = app;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog cmd %0d actual=hung expected=done", idx);
        end
    endtask

    task automatic t_reset();
        chk("R3 cs_n high in reset", cs_n, 1);
        chk("R12 no spi_start in reset", spi_start, 0);
        chk("R12 not busy after reset", busy, 0);
    endtask

    task automatic t_cmd0();
        prep(8'hFF);
        rx_script[8] = 8'h01;              // second poll
        run_cmd(6'd0, 32'h0, 2'd0, 1'b0);
        chk("R1 byte0 CMD0", tx_log[1], 8'h40);
        chk("R2 crc CMD0", tx_log[6], 8'h95);
        chk("R3 select byte cs high", cs_log[0], 1);
        chk("R3 frame cs low", cs_log[1], 0);
        chk("R3 deselect byte cs high", cs_log[9], 1);
        chk("R4 r1 from second poll", r1_status, 8'h01);
        chk("R4 byte count CMD0", nbytes, 10);
        chk("R3 cs high at done", cs_n, 1);
        @(negedge clk);
        chk("R12 done single pulse", done, 0);
        chk("R12 r1 held", r1_status, 8'h01);
    endtask

    task automatic t_cmd8_trailer();
        prep(8'hFF);
        rx_script[7]  = 8'h01;
        rx_script[8]  = 8'h00;
        rx_script[9]  = 8'h00;
        rx_script[10] = 8'h01;
        rx_script[11] = 8'hAA;
        run_cmd(6'd8, 32'h0000_01AA, 2'd2, 1'b0);
        chk("R1 byte0 CMD8", tx_log[1], 8'h48);
        chk("R1 arg byte 3", tx_log[4], 8'h01);
        chk("R1 arg byte 4", tx_log[5], 8'hAA);
        chk("R2 crc CMD8", tx_log[6], 8'h87);
        chk("R7 trailer word", trailer, 32'h0000_01AA);
        chk("R7 byte count", nbytes, 13);
    endtask

    task automatic t_stop_busy();
        prep(8'hFF);
        rx_script[7]  = 8'h05;             // stuff byte, must be discarded
        rx_script[8]  = 8'h00;
        rx_script[9]  = 8'h00;
        rx_script[10] = 8'h00;
        rx_script[11] = 8'hFF;
        run_cmd(6'd12, 32'h0, 2'd1, 1'b0);
        chk("R2 crc other cmd", tx_log[6], 8'hFF);
        chk("R5 stuff byte discarded", r1_status, 8'h00);
        chk("R8 busy ends on FF", nbytes, 13);
        chk("R8 no timeout", busy_timeout, 0);
        chk("R7 trailer zero for R1b", trailer, 0);
    endtask

    task automatic t_no_response();
        prep(8'hFF);
        run_cmd(6'd17, 32'h0, 2'd0, 1'b0);
        chk("R6 no_response flag", no_response, 1);
        chk("R6 r1 reads FF", r1_status, 8'hFF);
        chk("R6 three attempts byte count", nbytes, 68);
        chk("R6 second attempt reframed", tx_log[23], 8'h51);
    endtask

    task automatic t_retry_ok();
        prep(8'hFF);
        rx_script[30] = 8'h00;
        run_cmd(6'd16, 32'h0000_0200, 2'd0, 1'b0);
        chk("R6 retry success flag", no_response, 0);
        chk("R6 retry success r1", r1_status, 8'h00);
        chk("R6 retry byte count", nbytes, 32);
    endtask

    task automatic t_poll_edge();
        prep(8'hFF);
        rx_script[22] = 8'h00;             // sixteenth poll
        run_cmd(6'd13, 32'h0, 2'd0, 1'b0);
        chk("R4 last poll accepted", no_response, 0);
        chk("R4 last poll byte count", nbytes, 24);
    endtask

    task automatic t_busy_timeout();
        prep(8'h00);
        run_cmd(6'd38, 32'h0, 2'd1, 1'b0);
        chk("R9 timeout flag", busy_timeout, 1);
        chk("R9 r1 kept", r1_status, 8'h00);
        chk("R9 last byte deselected", cs_log[nbytes-1], 1);
        chk("R9 cs high after", cs_n, 1);
    endtask

    task automatic t_app();
        prep(8'hFF);
        rx_script[7]  = 8'h01;             // CMD55 reply
        rx_script[8]  = 8'h00;             // not ready
        rx_script[9]  = 8'hFF;             // ready
        rx_script[16] = 8'h00;
        run_cmd(6'd41, 32'h4000_0000, 2'd0, 1'b1);
        chk("R10 CMD55 first", tx_log[1], 8'h77);
        chk("R10 CMD55 crc", tx_log[6], 8'hFF);
        chk("R10 command after ready", tx_log[10], 8'h69);
        chk("R10 arg msb", tx_log[11], 8'h40);
        chk("R10 r1", r1_status, 8'h00);
        chk("R10 byte count", nbytes, 18);
    endtask

    task automatic t_illegal();
        prep(8'hFF);
        rx_script[7] = 8'h05;
        rx_script[8] = 8'h12;
        run_cmd(6'd8, 32'h0000_01AA, 2'd2, 1'b0);
        chk("R11 r1 illegal", r1_status, 8'h05);
        chk("R11 trailer not read", trailer, 0);
        chk("R11 byte count", nbytes, 9);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) rx_script[i] = 8'hFF;
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cmd0();
        t_cmd8_trailer();
        t_stop_busy();
        t_no_response();
        t_retry_ok();
        t_poll_edge();
        t_busy_timeout();
        t_app();
        t_illegal();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule